// File: doc/BRIEF.md
# Synthesizer Reference Divider and Phase Comparator

This block is the comparison stage of a frequency synthesizer. It runs entirely on the crystal oscillator clock. A counter divides the oscillator down to a low-rate comparison pulse, and a frequency-select input picks one of two ratios. With a 10.24 MHz oscillator, the two ratios give 10 kHz or 5 kHz. A second output toggles on every oscillator cycle, so it carries the oscillator rate halved. A frequency tripler or a neighbouring clocked block can use it.

The comparison pulse is matched against the divided feedback pulse. The feedback pulse comes from an external feedback divider and is already synchronised to the oscillator clock. A two-state phase-frequency detector makes the comparison. Its steering output goes high when the reference arrives first, which means the feedback is too slow. It goes low when the feedback arrives first, and it holds its level otherwise. The lock flag stays high while both edges line up. It drops low for one oscillator cycle per cycle of phase mismatch. Changing the select input restarts the divider, so the comparator never sees a shortened period.

Top module: `refdet_top`

## Requirements
- R1: With `freq_sel`=1, `ref_pulse` is high for exactly one cycle every 1024 oscillator cycles. The first pulse follows the 1024th rising edge after reset is released.
- R2: With `freq_sel`=0, the period of `ref_pulse` is 2048 cycles.
- R3: `half_clk` is low in reset and inverts on every rising edge after reset.
- R4: If the reference pulse reaches the detector d cycles (d≥1) before the feedback pulse, `steer` is high from two edges after the reference pulse is sampled.
- R5: If the feedback pulse reaches the detector before the reference pulse, `steer` is driven low.
- R6: If both pulses reach the detector in the same cycle, or neither is pending, `steer` keeps its previous level.
- R7: `locked` is low for exactly one cycle per cycle in which only one of the detector's up/down states is set. With a lead or lag of d cycles this gives d low cycles per period. `locked` is high at all other times.
- R8: Once both up and down states are set, both clear on the next edge. The next comparison period then starts from an empty state.
- R9: A change of `freq_sel` restarts the reference count at the edge that samples it. Any pulse due at that edge is suppressed. The next pulse comes exactly one new period later.
- R10: While `rst` is high: `ref_pulse`=0, `half_clk`=0, `steer`=0, `locked`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | 1 | 1: ratio 1024, 0: ratio 2048 |
| fb_pulse | input | 1 | One-cycle feedback pulse, synchronous to clk |
| half_clk | output | 1 | Oscillator divided by 2 |
| ref_pulse | output | 1 | One-cycle comparison pulse |
| steer | output | 1 | Loop-control output (high = raise VCO frequency) |
| locked | output | 1 | High when in phase, low during mismatch cycles |

## Verification
The detector is driven with the feedback pulse placed before, after and exactly on the reference pulse, at offsets of 1 to 7 cycles. Lag cases separate the high steering level and lead cases the low level. Coincident edges show the hold behaviour, and the count of low lock cycles per period measures the offset. The select input is changed in mid-period and again exactly at the edge where a pulse is due. This separates a true restart from a counter that simply switches its limit.

// File: rtl/refdet_pkg.sv
package refdet_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_state_t;

  localparam pfd_state_t PFD_IDLE = '{up: 1'b0, dn: 1'b0};

  function automatic logic pfd_mismatch(pfd_state_t s);
    return s.up ^ s.dn;
  endfunction
endpackage

// File: rtl/refdet_refdiv.sv
module refdet_refdiv #(
  parameter int DIV_FAST = 1024,
  parameter int DIV_SLOW = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic freq_sel,
  output logic ref_pulse
);
  localparam int MAXDIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW     = $clog2(MAXDIV) + 1;
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);

  logic [CW-1:0] cnt_q;
  logic          sel_q;
  logic [CW-1:0] limit;

  assign limit = sel_q ? LIM_FAST : LIM_SLOW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      sel_q     <= freq_sel;
      ref_pulse <= 1'b0;
    end else if (freq_sel != sel_q) begin
      // restart: no shortened period reaches the detector
      cnt_q     <= '0;
      sel_q     <= freq_sel;
      ref_pulse <= 1'b0;
    end else if (cnt_q == limit) begin
      cnt_q     <= '0;
      ref_pulse <= 1'b1;
    end else begin
      cnt_q     <= cnt_q + 1'b1;
      ref_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/refdet_half.sv
module refdet_half (
  input  logic clk,
  input  logic rst,
  output logic half_clk
);
  always_ff @(posedge clk) begin
    if (rst) half_clk <= 1'b0;
    else     half_clk <= ~half_clk;
  end
endmodule

// File: rtl/refdet_pfd.sv
module refdet_pfd
  import refdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic       fb_in,
  output pfd_state_t state,
  output logic       steer,
  output logic       locked
);
  logic       both;
  pfd_state_t nxt;

  always_comb begin
    both   = state.up & state.dn;
    nxt.up = (state.up & ~both) | ref_in;
    nxt.dn = (state.dn & ~both) | fb_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PFD_IDLE;
      steer  <= 1'b0;
      locked <= 1'b1;
    end else begin
      state  <= nxt;
      locked <= ~pfd_mismatch(state);
      if (state.up & ~state.dn)      steer <= 1'b1;
      else if (state.dn & ~state.up) steer <= 1'b0;
    end
  end
endmodule

// File: rtl/refdet_top.sv
module refdet_top
  import refdet_pkg::*;
#(
  parameter int DIV_FAST = 1024,
  parameter int DIV_SLOW = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic freq_sel,
  input  logic fb_pulse,
  output logic half_clk,
  output logic ref_pulse,
  output logic steer,
  output logic locked
);
  pfd_state_t pfd_st;

  refdet_refdiv #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk(clk), .rst(rst), .freq_sel(freq_sel), .ref_pulse(ref_pulse)
  );

  refdet_half u_half (.clk(clk), .rst(rst), .half_clk(half_clk));

  refdet_pfd u_pfd (
    .clk(clk), .rst(rst), .ref_in(ref_pulse), .fb_in(fb_pulse),
    .state(pfd_st), .steer(steer), .locked(locked)
  );
endmodule

// File: rtl/refdet_chk.sv
module refdet_chk (
  input logic clk,
  input logic rst,
  input logic freq_sel,
  input logic ref_pulse,
  input logic half_clk,
  input logic steer,
  input logic locked,
  input logic st_up,
  input logic st_dn
);
  p_pulse_width_r1: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);
  p_half_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (half_clk != $past(half_clk)));
  p_steer_up_r4: assert property (@(posedge clk) disable iff (rst)
    (st_up && !st_dn) |=> steer);
  p_steer_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (st_dn && !st_up) |=> !steer);
  p_steer_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st_up == st_dn) |=> $stable(steer));
  p_lock_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (st_up != st_dn) |=> !locked);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (st_up && st_dn && !ref_pulse) |=> !st_up);
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_sel) |=> !ref_pulse);
endmodule

bind refdet_top refdet_chk u_chk (
  .clk(clk), .rst(rst), .freq_sel(freq_sel), .ref_pulse(ref_pulse),
  .half_clk(half_clk), .steer(steer), .locked(locked),
  .st_up(pfd_st.up), .st_dn(pfd_st.dn)
);

// File: tb/refdet_top_test.sv
module refdet_top_test;
  localparam int TCLK = 10;
  localparam int RF = 1024;
  localparam int RS = 2048;

  typedef struct { int lows; bit det; } win_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic freq_sel = 1'b1;
  logic fb_pulse = 1'b0;
  logic half_clk, ref_pulse, steer, locked;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  ref_chk = 1'b0;
  bit  pfd_chk = 1'b0;
  int  lowcnt = 0;
  int  ref_q[$];
  win_t win_q[$];

  refdet_top uut (
    .clk(clk), .rst(rst), .freq_sel(freq_sel), .fb_pulse(fb_pulse),
    .half_clk(half_clk), .ref_pulse(ref_pulse), .steer(steer), .locked(locked)
  );

  always #(TCLK/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: reference pulse timing and per-period detector windows
  always @(negedge clk) begin
    if (!rst && ref_chk && ref_pulse) begin
      if (ref_q.size() == 0) chk(1'b0, "R1/R2/R9 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = ref_q.pop_front();
        chk(cyc == e, "R1/R2/R9 pulse cycle", cyc, e);
      end
    end
    if (pfd_chk) begin
      int l;
      l = lowcnt + (locked ? 0 : 1);
      if (cyc > RF/2 && (cyc % RF) == RF/2) begin
        win_t w;
        w = win_q.pop_front();
        chk(l == w.lows, "R7/R8 lock low cycles", l, w.lows);
        chk(steer == w.det, "R4/R5/R6 steer level", int'(steer), int'(w.det));
        lowcnt <= 0;
      end else lowcnt <= l;
    end else lowcnt <= 0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int offs[8] = '{3, -5, 0, 1, 0, 7, -1, 2};
    bit prev;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(ref_pulse == 1'b0, "R10 ref_pulse", int'(ref_pulse), 0);
    chk(half_clk == 1'b0, "R10 half_clk", int'(half_clk), 0);
    chk(steer == 1'b0, "R10 steer", int'(steer), 0);
    chk(locked == 1'b1, "R10 locked", int'(locked), 1);

    // phase A: R1 period, detector scenarios
    prev = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      win_t w;
      int d;
      ref_q.push_back(k * RF);
      d = offs[k-1];
      w.lows = (d < 0) ? -d : d;
      w.det  = (d > 0) ? 1'b1 : (d < 0) ? 1'b0 : prev;
      prev   = w.det;
      win_q.push_back(w);
    end
    rst = 1'b0;
    ref_chk = 1'b1;
    pfd_chk = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk(half_clk == cyc[0], "R3 half_clk toggle", int'(half_clk), cyc % 2);
    end
    for (int k = 1; k <= 8; k++) begin
      wait_cyc(k * RF + offs[k-1]);
      fb_pulse = 1'b1;
      @(negedge clk);
      fb_pulse = 1'b0;
    end
    wait_cyc(8 * RF + RF/2 + 2);
    pfd_chk = 1'b0;
    chk(ref_q.size() == 0, "R1 all pulses seen", ref_q.size(), 0);
    chk(win_q.size() == 0, "R7 all windows seen", win_q.size(), 0);

    // phase B: select changes (R2, R9)
    ref_chk = 1'b0;
    rst = 1'b1;
    freq_sel = 1'b1;
    repeat (3) @(negedge clk);
    ref_q.push_back(RF);
    ref_q.push_back(1501 + RS);
    ref_q.push_back(1501 + 2 * RS);
    ref_q.push_back(6001 + RF);
    ref_q.push_back(8049 + RS);
    ref_q.push_back(8049 + 2 * RS);
    rst = 1'b0;
    ref_chk = 1'b1;
    wait_cyc(1500);
    freq_sel = 1'b0;
    wait_cyc(6000);
    freq_sel = 1'b1;
    wait_cyc(8048);
    freq_sel = 1'b0;   // sampled at the edge where a pulse is due: suppressed
    @(negedge clk);
    chk(ref_pulse == 1'b0, "R9 suppressed pulse", int'(ref_pulse), 0);
    wait_cyc(8049 + 2 * RS + 2);
    chk(ref_q.size() == 0, "R2/R9 all pulses seen", ref_q.size(), 0);
    finish_run();
  end
endmodule